// File: doc/BRIEF.md
# Two-Stage Overvoltage Trip and Alarm Logic

This block is the digital decision logic behind a two-stage overvoltage protection function. A front end, outside the block, supplies a sample strobe, one overvoltage comparator flag per stage, and the measured voltage magnitude. The magnitude is expressed as a multiple of the voltage setting, in eighths, so the value 8 means exactly 1.0 times the setting. Stage 1 drives a trip output. Stage 2 drives an alarm output. Each stage has an external block input and an external instant-operate input.

Stage 1 has a three-way mode setting. In off mode the stage is silent. In definite-time mode, trip follows a fixed run of consecutive overvoltage samples. In inverse-time mode, an accumulator integrates a voltage-dependent step on every sample, so a larger overvoltage trips sooner, and a time multiplier stretches the curve. Stage 2 has a definite-time delay only, and is switched by its own enable input.

Both outputs come from registers and drop low one clock after the conditions that raised them are removed. Any change of the stage 1 mode clears every timer and the accumulator.

Top module: `ov_stage_trip`

## Requirements
- R1: `s1_mode` encodes 0 = off, 1 = definite-time, 2 = inverse-time. Code 3 behaves as off. In off mode `s1_trip` stays low, even when `s1_inst` is high.
- R2: In definite-time mode, `s1_trip` rises after `s1_dly` consecutive strobes with `s1_ov` high, and not after one fewer.
- R3: A strobe that sees the stage's comparator flag low clears its definite-time count. The output falls two clocks later, and the full delay must then elapse again.
- R4: In inverse-time mode, each strobe adds `vmag`−8 to the accumulator, with `vmag` clamped to 24 (3.0 times the setting). Trip rises once the sum reaches `IDMT_THR`×`s1_tms`; a `s1_tms` of 0 counts as 1. With the default threshold of 64 and `s1_tms`=1, 2.0 times the setting takes 8 strobes, 3.0 times takes 4, and exactly 1.0 times never trips.
- R5: In inverse-time mode, a strobe with `vmag` below 8, or with `s1_ov` low, resets the accumulator and drops the trip.
- R6: The inverse-time delay scales with the multiplier: `s1_tms`=2 doubles the strobe count of `s1_tms`=1.
- R7: `s1_blk` forces `s1_trip` low on the next clock and overrides `s1_inst`. Blocking does not stop the timers, so releasing the block restores a trip whose delay has already run out.
- R8: In definite-time or inverse-time mode, `s1_inst` raises `s1_trip` on the next clock, whatever the timers hold.
- R9: A change of `s1_mode` clears the definite-time counter, the accumulator and the stage 2 counter.
- R10: `s2_alarm` rises after `s2_dly` consecutive strobes with `s2_ov` high, and follows R3 when `s2_ov` is low.
- R11: `s2_alarm` is held low while `s2_en` is low or `s2_blk` is high, including against `s2_inst`. Otherwise `s2_inst` raises the alarm on the next clock.
- R12: Both outputs are registered and are low after synchronous reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-clock sample strobe |
| s1_ov | input | 1 | Stage 1 comparator flag |
| s2_ov | input | 1 | Stage 2 comparator flag |
| vmag | input | 8 | Voltage as a multiple of the setting, in eighths |
| s1_mode | input | 2 | Stage 1 mode: 0 off, 1 definite, 2 inverse |
| s1_dly | input | CNT_W | Stage 1 definite delay, in strobes |
| s1_tms | input | TMS_W | Inverse-time multiplier |
| s1_blk | input | 1 | Stage 1 block |
| s1_inst | input | 1 | Stage 1 instant operate |
| s2_en | input | 1 | Stage 2 enable |
| s2_dly | input | CNT_W | Stage 2 delay, in strobes |
| s2_blk | input | 1 | Stage 2 block |
| s2_inst | input | 1 | Stage 2 instant operate |
| s1_trip | output | 1 | Stage 1 trip |
| s2_alarm | output | 1 | Stage 2 alarm |

## Verification
The bench targets the edges of each delay: one strobe short of the definite and inverse delays, and exactly on them. A timer that counts one sample early or late fails there. It also holds the voltage at exactly 1.0 and beyond 3.0 times the setting. A wrong step function would then trip at the knee, or overflow the step and trip late or never. It asserts block and instant together to catch a reversed priority, switches the mode back and forth mid-delay to expose a timer that is not cleared, and drives instant-operate in both off codes to show that off mode really suppresses it.

// File: rtl/ov_pkg.sv
package ov_pkg;

    localparam int OV_MAG_W  = 8;
    localparam int OV_STEP_W = 5;
    localparam int OV_ONE    = 8;
    localparam int OV_CLAMP  = 24;

    typedef enum logic [1:0] {
        OVM_OFF  = 2'd0,
        OVM_DT   = 2'd1,
        OVM_IDMT = 2'd2,
        OVM_RSV  = 2'd3
    } ov_mode_e;

    typedef struct packed {
        logic en;
        logic blk;
        logic inst;
        logic timed;
    } ov_gate_t;

    function automatic logic gate_fire(input ov_gate_t g);
        return g.en && !g.blk && (g.inst || g.timed);
    endfunction

    function automatic logic [OV_STEP_W-1:0] idmt_step(input logic [OV_MAG_W-1:0] m);
        if (int'(m) < OV_ONE)
            return '0;
        else if (int'(m) > OV_CLAMP)
            return OV_STEP_W'(OV_CLAMP - OV_ONE);
        else
            return OV_STEP_W'(int'(m) - OV_ONE);
    endfunction

endpackage

// File: rtl/ov_pickup_timer.sv
module ov_pickup_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             stb,
    input  logic             cond,
    input  logic [CNT_W-1:0] dly,
    output logic             done
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = (cnt >= dly) ? cnt : cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (stb) begin
            if (!cond) begin
                cnt  <= '0;
                done <= 1'b0;
            end else begin
                cnt  <= cnt_nxt;
                done <= (cnt_nxt >= dly);
            end
        end
    end
endmodule

// File: rtl/ov_inverse_integ.sv
module ov_inverse_integ
    import ov_pkg::*;
#(
    parameter int ACC_W    = 16,
    parameter int TMS_W    = 4,
    parameter int IDMT_THR = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                stb,
    input  logic                cond,
    input  logic [OV_MAG_W-1:0] mag,
    input  logic [TMS_W-1:0]    tms,
    output logic                done
);
    logic [ACC_W-1:0]     acc;
    logic [ACC_W-1:0]     acc_nxt;
    logic [ACC_W-1:0]     lim;
    logic [ACC_W:0]       sum;
    logic [OV_STEP_W-1:0] step;
    logic                 live;

    always_comb begin
        step    = idmt_step(mag);
        live    = cond && (int'(mag) >= OV_ONE);
        lim     = ACC_W'(IDMT_THR * ((tms == '0) ? 1 : int'(tms)));
        sum     = {1'b0, acc} + (ACC_W + 1)'(step);
        acc_nxt = sum[ACC_W] ? '1 : sum[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc  <= '0;
            done <= 1'b0;
        end else if (stb) begin
            if (!live) begin
                acc  <= '0;
                done <= 1'b0;
            end else begin
                acc  <= acc_nxt;
                done <= (acc_nxt >= lim);
            end
        end
    end
endmodule

// File: rtl/ov_stage_trip.sv
module ov_stage_trip
    import ov_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int ACC_W    = 16,
    parameter int TMS_W    = 4,
    parameter int IDMT_THR = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_stb,
    input  logic                s1_ov,
    input  logic                s2_ov,
    input  logic [OV_MAG_W-1:0] vmag,
    input  logic [1:0]          s1_mode,
    input  logic [CNT_W-1:0]    s1_dly,
    input  logic [TMS_W-1:0]    s1_tms,
    input  logic                s1_blk,
    input  logic                s1_inst,
    input  logic                s2_en,
    input  logic [CNT_W-1:0]    s2_dly,
    input  logic                s2_blk,
    input  logic                s2_inst,
    output logic                s1_trip,
    output logic                s2_alarm
);
    localparam int STAGES = 2;

    ov_mode_e mode;
    ov_mode_e mode_q;
    logic     mode_chg;
    logic     s1_on;
    logic     dt_done;
    logic     id_done;
    logic     s2_done;

    ov_gate_t              gate [STAGES];
    logic [STAGES-1:0]     out_q;

    assign mode     = ov_mode_e'(s1_mode);
    assign mode_chg = (mode != mode_q);
    assign s1_on    = (mode == OVM_DT) || (mode == OVM_IDMT);

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= OVM_OFF;
        else
            mode_q <= mode;
    end

    ov_pickup_timer #(.CNT_W(CNT_W)) u_dt1 (
        .clk  (clk),
        .rst  (rst),
        .clr  (mode_chg || (mode != OVM_DT)),
        .stb  (smp_stb),
        .cond (s1_ov),
        .dly  (s1_dly),
        .done (dt_done)
    );

    ov_inverse_integ #(.ACC_W(ACC_W), .TMS_W(TMS_W), .IDMT_THR(IDMT_THR)) u_inv1 (
        .clk  (clk),
        .rst  (rst),
        .clr  (mode_chg || (mode != OVM_IDMT)),
        .stb  (smp_stb),
        .cond (s1_ov),
        .mag  (vmag),
        .tms  (s1_tms),
        .done (id_done)
    );

    ov_pickup_timer #(.CNT_W(CNT_W)) u_dt2 (
        .clk  (clk),
        .rst  (rst),
        .clr  (mode_chg),
        .stb  (smp_stb),
        .cond (s2_ov),
        .dly  (s2_dly),
        .done (s2_done)
    );

    always_comb begin
        gate[0] = '{en: s1_on, blk: s1_blk, inst: s1_inst,
                    timed: (mode == OVM_DT) ? dt_done : ((mode == OVM_IDMT) ? id_done : 1'b0)};
        gate[1] = '{en: s2_en, blk: s2_blk, inst: s2_inst, timed: s2_done};
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_out
        logic q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= 1'b0;
            else
                q <= gate_fire(gate[s]);
        end
        assign out_q[s] = q;
    end

    assign s1_trip  = out_q[0];
    assign s2_alarm = out_q[1];
endmodule

// File: rtl/ov_stage_chk.sv
module ov_stage_chk (
    input logic       clk,
    input logic       rst,
    input logic       smp_stb,
    input logic       s2_ov,
    input logic [1:0] s1_mode,
    input logic       s1_blk,
    input logic       s1_inst,
    input logic       s2_en,
    input logic       s2_blk,
    input logic       s2_inst,
    input logic       s1_trip,
    input logic       s2_alarm
);
    p_off_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (s1_mode != 2'd1 && s1_mode != 2'd2) |=> !s1_trip);

    p_blk_wins_r7: assert property (@(posedge clk) disable iff (rst)
        s1_blk |=> !s1_trip);

    p_inst_fast_r8: assert property (@(posedge clk) disable iff (rst)
        (s1_inst && !s1_blk && (s1_mode == 2'd1 || s1_mode == 2'd2)) |=> s1_trip);

    p_s2_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && !s2_ov) |=> ##1 (!s2_alarm || $past(s2_inst)));

    p_s2_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (!s2_en || s2_blk) |=> !s2_alarm);

    p_s2_inst_r11: assert property (@(posedge clk) disable iff (rst)
        (s2_inst && s2_en && !s2_blk) |=> s2_alarm);
endmodule

bind ov_stage_trip ov_stage_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .smp_stb  (smp_stb),
    .s2_ov    (s2_ov),
    .s1_mode  (s1_mode),
    .s1_blk   (s1_blk),
    .s1_inst  (s1_inst),
    .s2_en    (s2_en),
    .s2_blk   (s2_blk),
    .s2_inst  (s2_inst),
    .s1_trip  (s1_trip),
    .s2_alarm (s2_alarm)
);

// File: tb/sim_ov_stage_trip.sv
module sim_ov_stage_trip;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_stb = 1'b0;
    logic       s1_ov = 1'b0;
    logic       s2_ov = 1'b0;
    logic [7:0] vmag = 8'd0;
    logic [1:0] s1_mode = 2'd0;
    logic [7:0] s1_dly = 8'd5;
    logic [3:0] s1_tms = 4'd1;
    logic       s1_blk = 1'b0;
    logic       s1_inst = 1'b0;
    logic       s2_en = 1'b0;
    logic [7:0] s2_dly = 8'd3;
    logic       s2_blk = 1'b0;
    logic       s2_inst = 1'b0;
    logic       s1_trip;
    logic       s2_alarm;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ov_stage_trip u0 (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .s1_ov(s1_ov), .s2_ov(s2_ov),
        .vmag(vmag), .s1_mode(s1_mode), .s1_dly(s1_dly), .s1_tms(s1_tms),
        .s1_blk(s1_blk), .s1_inst(s1_inst), .s2_en(s2_en), .s2_dly(s2_dly),
        .s2_blk(s2_blk), .s2_inst(s2_inst), .s1_trip(s1_trip), .s2_alarm(s2_alarm)
    );

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) smp_stb = 1'b1;
            @(negedge clk) smp_stb = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic clear_s1();
        s1_ov = 1'b0;
        strobes(1);
        s1_ov = 1'b1;
    endtask

    task automatic t_reset();
        chk(s1_trip, 1'b0, "R12 trip after reset");
        chk(s2_alarm, 1'b0, "R12 alarm after reset");
    endtask

    task automatic t_definite();
        s1_mode = 2'd1; s1_dly = 8'd5; s1_ov = 1'b1;
        @(negedge clk);
        strobes(4);
        chk(s1_trip, 1'b0, "R2 one strobe short");
        strobes(1);
        chk(s1_trip, 1'b1, "R2 delay reached");
        s1_ov = 1'b0;
        strobes(1);
        chk(s1_trip, 1'b0, "R3 drop on low flag");
        s1_ov = 1'b1;
        strobes(4);
        chk(s1_trip, 1'b0, "R3 count restarted");
        strobes(1);
        chk(s1_trip, 1'b1, "R3 full delay again");
    endtask

    task automatic t_block();
        @(negedge clk) s1_blk = 1'b1;
        @(negedge clk);
        chk(s1_trip, 1'b0, "R7 block drops trip");
        s1_inst = 1'b1;
        @(negedge clk);
        chk(s1_trip, 1'b0, "R7 block over instant");
        s1_inst = 1'b0; s1_blk = 1'b0;
        @(negedge clk);
        chk(s1_trip, 1'b1, "R7 expired trip restored");
    endtask

    task automatic t_instant();
        clear_s1();
        s1_ov = 1'b0;
        chk(s1_trip, 1'b0, "R8 idle before instant");
        s1_inst = 1'b1;
        @(negedge clk);
        chk(s1_trip, 1'b1, "R8 instant in definite mode");
        s1_mode = 2'd2;
        @(negedge clk);
        @(negedge clk);
        chk(s1_trip, 1'b1, "R8 instant in inverse mode");
        s1_mode = 2'd0;
        @(negedge clk);
        chk(s1_trip, 1'b0, "R1 instant ignored when off");
        s1_mode = 2'd3;
        @(negedge clk);
        chk(s1_trip, 1'b0, "R1 code 3 acts as off");
        s1_ov = 1'b1;
        strobes(6);
        chk(s1_trip, 1'b0, "R1 off mode never times out");
        s1_inst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_inverse();
        s1_mode = 2'd2; s1_tms = 4'd1; vmag = 8'd16; s1_ov = 1'b1;
        @(negedge clk);
        strobes(7);
        chk(s1_trip, 1'b0, "R4 2x one strobe short");
        strobes(1);
        chk(s1_trip, 1'b1, "R4 2x at 8 strobes");
        vmag = 8'd7;
        strobes(1);
        chk(s1_trip, 1'b0, "R5 below setting resets");
        vmag = 8'd24;
        strobes(3);
        chk(s1_trip, 1'b0, "R4 3x one strobe short");
        strobes(1);
        chk(s1_trip, 1'b1, "R4 3x at 4 strobes");
        s1_ov = 1'b0;
        strobes(1);
        chk(s1_trip, 1'b0, "R5 low flag resets");
        s1_ov = 1'b1; vmag = 8'd40;
        strobes(3);
        chk(s1_trip, 1'b0, "R4 clamp one strobe short");
        strobes(1);
        chk(s1_trip, 1'b1, "R4 clamp at 4 strobes");
        vmag = 8'd8;
        clear_s1();
        strobes(20);
        chk(s1_trip, 1'b0, "R4 exactly 1x never trips");
        vmag = 8'd16; s1_tms = 4'd2;
        clear_s1();
        strobes(15);
        chk(s1_trip, 1'b0, "R6 tms 2 one strobe short");
        strobes(1);
        chk(s1_trip, 1'b1, "R6 tms 2 at 16 strobes");
        s1_tms = 4'd0;
        clear_s1();
        strobes(7);
        chk(s1_trip, 1'b0, "R4 tms 0 one strobe short");
        strobes(1);
        chk(s1_trip, 1'b1, "R4 tms 0 acts as 1");
    endtask

    task automatic t_mode_clear();
        s1_mode = 2'd1; s1_dly = 8'd5; s1_ov = 1'b1;
        clear_s1();
        strobes(4);
        @(negedge clk) s1_mode = 2'd2;
        @(negedge clk) s1_mode = 2'd1;
        @(negedge clk);
        strobes(4);
        chk(s1_trip, 1'b0, "R9 mode change cleared timer");
        strobes(1);
        chk(s1_trip, 1'b1, "R9 full delay after change");
        s1_ov = 1'b0; s1_mode = 2'd0;
        strobes(1);
    endtask

    task automatic t_stage2();
        s2_en = 1'b1; s2_dly = 8'd3; s2_ov = 1'b1;
        @(negedge clk);
        strobes(2);
        chk(s2_alarm, 1'b0, "R10 one strobe short");
        strobes(1);
        chk(s2_alarm, 1'b1, "R10 delay reached");
        s2_ov = 1'b0;
        strobes(1);
        chk(s2_alarm, 1'b0, "R10 drop on low flag");
        s2_en = 1'b0; s2_inst = 1'b1;
        @(negedge clk);
        chk(s2_alarm, 1'b0, "R11 disabled blocks instant");
        s2_en = 1'b1; s2_blk = 1'b1;
        @(negedge clk);
        chk(s2_alarm, 1'b0, "R11 block over instant");
        s2_blk = 1'b0;
        @(negedge clk);
        chk(s2_alarm, 1'b1, "R11 instant raises alarm");
        s2_inst = 1'b0;
        @(negedge clk);
        chk(s2_alarm, 1'b0, "R11 alarm falls with instant");
        s2_ov = 1'b1; s1_mode = 2'd1;
        strobes(2);
        @(negedge clk) s1_mode = 2'd0;
        @(negedge clk);
        strobes(2);
        chk(s2_alarm, 1'b0, "R9 mode change cleared stage 2");
        strobes(1);
        chk(s2_alarm, 1'b1, "R9 stage 2 full delay after change");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_definite();
        t_block();
        t_instant();
        t_inverse();
        t_mode_clear();
        t_stage2();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule